// File: doc/BRIEF.md
# Latched serial-to-parallel sink driver

This block turns a serial bit stream into a bank of pull-down controls. Each rising edge of the shift clock moves one bit into a chain of registers. Behind each register sits a storage latch. The latch is transparent while the capture input is high and holds its bit while that input is low. A gating input decides whether the stored bits reach the outputs. Each output turns on a pull-down that sinks load current, for example for an LED or a relay coil.

Every output has two forms. The first is a sink-enable bit, which is high when its latch holds a one and the outputs are enabled. The second is a tri-state pin that is driven to zero while the sink-enable bit is high and floats otherwise.

Two serial taps pass the last stage on to a following instance. One tap changes on the rising edge. The other re-times the same bit to the next falling edge, which gives slow-edged clocks half a period of margin. Chaining instances through either tap forms one longer register.

Top module: `sipo_od_driver`

## Requirements
- R1: While `rst_n` is low, all shift stages, all latches and both serial taps are zero, so every sink-enable bit is zero whatever the other inputs do.
- R2: On each rising `sclk` edge, stage 0 takes `sdin` and every stage k>0 takes the old value of stage k-1.
- R3: While `latch_en` and `out_en` are both high, `sink_en` equals the shift stages and follows them as they change.
- R4: While `latch_en` is low, the latches keep their value, so `sink_en` does not change even when the chain shifts.
- R5: While `out_en` is low, every bit of `sink_en` is zero.
- R6: Toggling `out_en` changes neither the latches nor the stages. When it goes high again, `sink_en` shows the same stored bits as before.
- R7: `cas_rise` changes only on rising edges. After each rising edge it equals the new stage 11, which is the old stage 10.
- R8: `cas_fall` changes only on falling edges. At each falling edge it takes stage 11, so it lags `cas_rise` by half a period.
- R9: `pin_od[k]` is driven to 0 whenever `sink_en[k]` is 1. Otherwise it is left at high impedance.
- R10: Bit 0 of the outputs belongs to the stage that receives `sdin`, and bit 11 belongs to the last stage.
- R11: Two instances chained through either serial tap carry a 24-bit pattern intact: the second instance holds the first 12 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of stages, latches and taps |
| sclk | input | 1 | Shift clock |
| sdin | input | 1 | Serial data into stage 0 |
| latch_en | input | 1 | High: latches transparent; low: latches hold |
| out_en | input | 1 | High: stored bits reach the outputs |
| sink_en | output | 12 | Pull-down enable per output, bit 0 nearest `sdin` |
| pin_od | output | 12 | Tri-state pin view: 0 when sinking, Z when off |
| cas_rise | output | 1 | Cascade tap updated on rising edges |
| cas_fall | output | 1 | Cascade tap updated on falling edges |

## Verification
A wrong shift stage shows up on `sink_en` in the same cycle when the latches are transparent. With the latches closed it stays hidden until the next capture. It also reaches `cas_rise` after as many edges as it has stages left to travel. A latch that leaks while closed changes `sink_en` in the middle of a hold period. A fault in the falling-edge tap shows up within half a period, as a difference between the two taps. A corrupted bit in a two-instance chain appears in the combined 24-bit output as soon as the latches are opened.

// File: rtl/sipo_od_pkg.sv
`timescale 1ns/1ps
package sipo_od_pkg;
    // default number of stages in one driver
    localparam int unsigned DEF_STAGES = 12;
endpackage

// File: rtl/sipo_shift_chain.sv
`timescale 1ns/1ps
module sipo_shift_chain #(
    parameter int unsigned N = 12
) (
    input  logic         sclk,
    input  logic         rst_n,
    input  logic         sdin,
    output logic [N-1:0] stage_q,
    output logic         tail_q
);
    localparam int unsigned TOP = N - 1;

    // rising-edge shift: new bit at index 0, older bits move upward
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[TOP-1:0], sdin};
        end
    end

    assign tail_q = stage_q[TOP];
endmodule

// File: rtl/sipo_store_latch.sv
`timescale 1ns/1ps
module sipo_store_latch #(
    parameter int unsigned N = 12
) (
    input  logic         rst_n,
    input  logic         open_en,
    input  logic [N-1:0] din,
    output logic [N-1:0] held_q
);
    // level-sensitive storage, deliberately a latch
    always_latch begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (open_en) begin
            held_q <= din;
        end
    end
endmodule

// File: rtl/sipo_fall_tap.sv
`timescale 1ns/1ps
module sipo_fall_tap (
    input  logic sclk,
    input  logic rst_n,
    input  logic tail_d,
    output logic tap_q
);
    // re-time the last stage onto the falling edge
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
        end else begin
            tap_q <= tail_d;
        end
    end
endmodule

// File: rtl/sipo_od_driver.sv
`timescale 1ns/1ps
module sipo_od_driver
    import sipo_od_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              latch_en,
    input  logic              out_en,
    output logic [STAGES-1:0] sink_en,
    output wire  [STAGES-1:0] pin_od,
    output logic              cas_rise,
    output logic              cas_fall
);
    logic [STAGES-1:0] stage_bits;
    logic [STAGES-1:0] held_bits;
    logic              tail_bit;

    sipo_shift_chain #(.N(STAGES)) u_chain (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .sdin    (sdin),
        .stage_q (stage_bits),
        .tail_q  (tail_bit)
    );

    sipo_store_latch #(.N(STAGES)) u_store (
        .rst_n   (rst_n),
        .open_en (latch_en),
        .din     (stage_bits),
        .held_q  (held_bits)
    );

    sipo_fall_tap u_fall (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .tail_d (tail_bit),
        .tap_q  (cas_fall)
    );

    assign cas_rise = tail_bit;
    assign sink_en  = held_bits & {STAGES{out_en}};

    // open-drain pin view: pull low when sinking, float otherwise
    for (genvar k = 0; k < STAGES; k++) begin : g_pin
        assign pin_od[k] = sink_en[k] ? 1'b0 : 1'bz;
    end
endmodule

// File: rtl/sipo_od_driver_chk.sv
`timescale 1ns/1ps
module sipo_od_driver_chk #(
    parameter int unsigned N = 12
) (
    input logic         sclk,
    input logic         rst_n,
    input logic         sdin,
    input logic         latch_en,
    input logic         out_en,
    input logic [N-1:0] stage_bits,
    input logic [N-1:0] sink_en,
    input logic         cas_rise,
    input logic         cas_fall
);
    logic armed;
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    shift_move_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        armed |-> (stage_bits == {$past(stage_bits[N-2:0]), $past(sdin)}));

    // R3
    latch_follow_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (latch_en && out_en) |-> (sink_en == stage_bits));

    // R4
    latch_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (armed && !latch_en && !$past(latch_en) && out_en && $past(out_en))
        |-> $stable(sink_en));

    // R7
    rise_tap_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        armed |-> (cas_rise == $past(stage_bits[N-2])));

    // R8
    fall_tap_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        cas_fall == cas_rise);
endmodule

bind sipo_od_driver sipo_od_driver_chk #(.N(STAGES)) chk_i (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .sdin       (sdin),
    .latch_en   (latch_en),
    .out_en     (out_en),
    .stage_bits (stage_bits),
    .sink_en    (sink_en),
    .cas_rise   (cas_rise),
    .cas_fall   (cas_fall)
);

// File: tb/sipo_od_driver_tb_top.sv
`timescale 1ns/100ps
module sipo_od_driver_tb_top;
    localparam int unsigned N = 12;
    localparam int unsigned W = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdin = 1'b0;
    logic latch_en = 1'b0;
    logic out_en = 1'b0;

    logic [N-1:0] a_sink, b_sink, c_sink, d_sink;
    wire  [N-1:0] a_pin, b_pin, c_pin, d_pin;
    logic a_rise, a_fall, b_rise, b_fall, c_rise, c_fall, d_rise, d_fall;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [W-1:0] m24 = '0;   // model of the chained stages
    logic [W-1:0] l24 = '0;   // model of the chained latches

    always #2 clk = ~clk;     // 250 MHz

    // chain one: through the rising-edge tap
    sipo_od_driver #(.STAGES(N)) dut_i (
        .rst_n(rst_n), .sclk(clk), .sdin(sdin), .latch_en(latch_en), .out_en(out_en),
        .sink_en(a_sink), .pin_od(a_pin), .cas_rise(a_rise), .cas_fall(a_fall));
    sipo_od_driver #(.STAGES(N)) b_i (
        .rst_n(rst_n), .sclk(clk), .sdin(a_rise), .latch_en(latch_en), .out_en(out_en),
        .sink_en(b_sink), .pin_od(b_pin), .cas_rise(b_rise), .cas_fall(b_fall));
    // chain two: through the falling-edge tap
    sipo_od_driver #(.STAGES(N)) c_i (
        .rst_n(rst_n), .sclk(clk), .sdin(sdin), .latch_en(latch_en), .out_en(out_en),
        .sink_en(c_sink), .pin_od(c_pin), .cas_rise(c_rise), .cas_fall(c_fall));
    sipo_od_driver #(.STAGES(N)) d_i (
        .rst_n(rst_n), .sclk(clk), .sdin(c_fall), .latch_en(latch_en), .out_en(out_en),
        .sink_en(d_sink), .pin_od(d_pin), .cas_rise(d_rise), .cas_fall(d_fall));

    function automatic logic [W-1:0] exp_out(logic [W-1:0] lat, logic oe);
        return oe ? lat : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_sinks(input string tag);
        logic [W-1:0] e;
        e = exp_out(l24, out_en);
        chk(tag, 32'({b_sink, a_sink}), 32'(e));
        chk(tag, 32'({d_sink, c_sink}), 32'(e));
        // R9: pins with an active sink must be driven low
        chk("R9", 32'((a_pin & e[N-1:0]) | (b_pin & e[W-1:N])), 32'h0);
        chk("R9", 32'((c_pin & e[N-1:0]) | (d_pin & e[W-1:N])), 32'h0);
    endtask

    // one shift period; entered and left at posedge + 1 ns
    task automatic cycle(input logic d, input logic le, input logic oe);
        logic prev11;
        sdin = d; latch_en = le; out_en = oe;
        #0.5;
        if (le) l24 = m24;
        chk_sinks("R3 R4 R5");
        @(negedge clk); #1;
        chk("R8", 32'({a_fall, c_fall}), 32'({m24[N-1], m24[N-1]}));
        @(posedge clk); #1;
        prev11 = m24[N-1];
        m24 = {m24[W-2:0], d};
        if (le) l24 = m24;
        chk("R7", 32'({a_rise, c_rise, b_rise, d_rise}),
            32'({m24[N-1], m24[N-1], m24[W-1], m24[W-1]}));
        chk("R8", 32'({a_fall, c_fall}), 32'({prev11, prev11}));
        chk_sinks("R2 R3");
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] saved;
        logic [W-1:0] pat;
        void'($urandom(32'h5eed_0c4a));
        latch_en = 1'b1; out_en = 1'b1; sdin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state even with inputs active
        chk("R1", 32'({b_sink, a_sink}), 32'h0);
        chk("R1", 32'({d_sink, c_sink}), 32'h0);
        chk("R1", 32'({a_rise, a_fall, c_rise, c_fall}), 32'h0);
        rst_n = 1'b1;
        sdin = 1'b0;
        @(posedge clk); #1;
        m24 = '0; l24 = '0;
        chk("R1", 32'(a_sink), 32'h0);   // sdin was 0 at the first edge

        // R10: first bit lands at output 0, reaches output 11 after 12 edges
        cycle(1'b1, 1'b1, 1'b1);
        chk("R10", 32'(a_sink), 32'h001);
        for (int i = 0; i < N - 1; i++) cycle(1'b0, 1'b1, 1'b1);
        chk("R10", 32'(a_sink), 32'h800);
        chk("R10", 32'(a_rise), 32'h1);

        // R4: latches closed while the chain keeps shifting
        saved = a_sink;
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1);
        chk("R4", 32'(a_sink), 32'(saved));

        // R5/R6: gate off while shifting, then gate on with latches closed
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 1'b0);
        chk("R5", 32'(a_sink), 32'h0);
        out_en = 1'b1; #0.5;
        chk("R6", 32'(a_sink), 32'(saved));
        latch_en = 1'b1; #0.5;
        chk("R6", 32'({b_sink, a_sink}), 32'(m24));
        @(posedge clk); #1;
        m24 = {m24[W-2:0], sdin};
        l24 = m24;

        // R11: 24-bit pattern through both chains, latched at the end
        pat = 24'hC3A59E;
        for (int i = W - 1; i >= 0; i--) cycle(pat[i], 1'b0, 1'b1);
        latch_en = 1'b1; #0.5;
        chk("R11", 32'({b_sink, a_sink}), 32'(pat));
        chk("R11", 32'({d_sink, c_sink}), 32'(pat));
        @(posedge clk); #1;
        m24 = {m24[W-2:0], sdin};
        l24 = m24;

        // random traffic checked against the model
        for (int i = 0; i < 400; i++) begin
            logic rd, rl, ro;
            rd = 1'($urandom);
            rl = ($urandom % 4) != 0;
            ro = ($urandom % 5) != 0;
            cycle(rd, rl, ro);
        end

        // R1: reset mid-run clears everything at once
        latch_en = 1'b1; out_en = 1'b1; rst_n = 1'b0;
        #1;
        chk("R1", 32'({b_sink, a_sink}), 32'h0);
        chk("R1", 32'({d_sink, c_sink}), 32'h0);
        chk("R1", 32'({a_rise, a_fall, b_rise, b_fall}), 32'h0);
        chk("R1", 32'({c_rise, c_fall, d_rise, d_fall}), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule